// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-level memory address into a DIMM number, a rank within that DIMM, and the address as seen inside that rank. Up to four range entries are held in the block. Each entry has a valid flag, an upper bound and a way count. The first valid entry whose window covers the address is taken. The rank interleave is then undone at a granularity that depends on the page policy: the fine 64-byte step applies when closed-page mode is selected, and the coarse 8 KiB step applies otherwise.

The address bits just above the granularity give a way index. That index, together with the matched entry, selects one target word from a table of per-way words. The target word gives an offset, which is removed from the de-interleaved address, and a 4-bit channel-rank number. The channel-rank number is split into DIMM and rank. Configuration words are written one at a time through a simple write port. A decode starts with a one-cycle `start` pulse and finishes one cycle later.

Top module: `rank_ilv_decoder`

## Requirements
- R1: The granularity shift is 6 when `closed_page` is 1 and 13 when it is 0.
- R2: A range word is valid when its bit 31 is set. Its limit is bits 11..1 shifted left by 29, with the low 29 bits forced to one.
- R3: The entries are scanned in order from 0 to 3 with a lower bound that starts at zero. After each entry the bound becomes that entry's limit, whether or not the entry is valid, and nothing is added to it. An entry matches when it is valid and bound ≤ address ≤ limit. The lowest-numbered matching entry wins.
- R4: The way count of a range word is 1 shifted left by bits 29..28, which gives 1, 2, 4 or 8.
- R5: Before the offset is removed, the rank address is formed in three steps. The address bits above the shift are divided by the way count. The quotient is shifted back into place. The low shift bits of the address are kept unchanged.
- R6: The way index is (address >> shift) modulo the way count. The target word used is the one at [matched entry][way index].
- R7: The rank address output is the value from R5 minus the target word's bits 15..2 shifted left by 26, taken modulo 2^40. The channel rank is bits 19..16 of the target word.
- R8: `dimm` is channel rank divided by 4, and `rank` is channel rank modulo 4.
- R9: When no entry matches, `done` is still raised, `hit` is low, and `rank_addr`, `chan_rank`, `dimm` and `rank` are all zero.
- R10: `done` is high for exactly the cycle after each `start` cycle. At all other times the results keep their last values. After reset every output is zero.
- R11: A write with `cfg_is_tgt`=0 loads range word `cfg_entry`. A write with `cfg_is_tgt`=1 loads target word [`cfg_entry`][`cfg_way`]. All words reset to zero, which leaves every entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_tgt | input | 1 | 0 selects a range word, 1 selects a target word |
| cfg_entry | input | 2 | Range entry number |
| cfg_way | input | 3 | Way number, used for target words only |
| cfg_wdata | input | 32 | Word to write |
| start | input | 1 | Begin a decode of `chan_addr` |
| chan_addr | input | 40 | Channel address |
| closed_page | input | 1 | 1 for closed-page granularity |
| done | output | 1 | Result is ready |
| hit | output | 1 | An entry matched |
| rank_addr | output | 40 | Address within the rank |
| chan_rank | output | 4 | Channel-rank number |
| dimm | output | 2 | DIMM number |
| rank | output | 2 | Rank within the DIMM |

## Verification
The assertions assume two things. First, configuration writes never land in the same cycle as a `start` pulse, so the tables stay steady while a decode is sampled. Second, `start` is a single-cycle pulse. The bench keeps to both assumptions: every write finishes on its own clock edge before a decode begins, and each decode drives `start` for exactly one cycle before dropping it. The way-index property assumes that the way-count field never exceeds the table depth. This holds for every value of the 2-bit field.

// File: rtl/rid_pkg.sv
package rid_pkg;
    localparam int ADDR_W    = 40;
    localparam int N_ENT     = 4;
    localparam int MAX_WAYS  = 8;
    localparam int ENT_W     = $clog2(N_ENT);
    localparam int WAY_W     = $clog2(MAX_WAYS);
    localparam int N_TGT     = N_ENT * MAX_WAYS;
    localparam int CR_W      = 4;
    localparam int DIMM_W    = CR_W - 2;
    localparam int SH_CLOSED = 6;
    localparam int SH_OPEN   = 13;
    localparam int LIM_SHIFT = 29;
    localparam int OFS_SHIFT = 26;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [31:0]       word_t;

    typedef struct packed {
        logic            done;
        logic            hit;
        addr_t           raddr;
        logic [CR_W-1:0] cr;
    } res_t;

    // upper bound of a range word: field shifted up, low bits all ones
    function automatic addr_t range_limit(input word_t w);
        addr_t l;
        l = addr_t'(w[11:1]) << LIM_SHIFT;
        l = l | ((addr_t'(1) << LIM_SHIFT) - addr_t'(1));
        return l;
    endfunction
endpackage

// File: rtl/rid_cfg_regs.sv
module rid_cfg_regs
    import rid_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        is_tgt,
    input  logic [ENT_W-1:0]            ent,
    input  logic [WAY_W-1:0]            way,
    input  word_t                       wdata,
    input  logic [ENT_W-1:0]            rd_ent,
    input  logic [WAY_W-1:0]            rd_way,
    output logic [N_ENT-1:0][31:0]      rng,
    output word_t                       tgt_word
);
    logic [N_ENT-1:0][31:0] rng_d, rng_q;
    logic [N_TGT-1:0][31:0] tgt_d, tgt_q;

    always_comb begin
        rng_d = rng_q;
        tgt_d = tgt_q;
        if (we) begin
            if (is_tgt) tgt_d[{ent, way}] = wdata;
            else        rng_d[ent]        = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng_q <= '0;
            tgt_q <= '0;
        end else begin
            rng_q <= rng_d;
            tgt_q <= tgt_d;
        end
    end

    assign rng      = rng_q;
    assign tgt_word = tgt_q[{rd_ent, rd_way}];
endmodule

// File: rtl/rid_range_match.sv
module rid_range_match
    import rid_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_ENT-1:0][31:0] rng,
    input  addr_t                  addr,
    output logic                   hit,
    output logic [ENT_W-1:0]       ent
);
    addr_t lower;
    addr_t lim;
    logic  unused_rng;

    always_comb begin
        hit   = 1'b0;
        ent   = '0;
        lower = '0;
        lim   = '0;
        for (int e = 0; e < N_ENT; e++) begin
            lim = range_limit(rng[e]);
            if (!hit && rng[e][31] && (lower <= addr) && (addr <= lim)) begin
                hit = 1'b1;
                ent = ENT_W'(e);
            end
            // bound carries the previous limit as-is, no increment
            lower = lim;
        end
    end

    assign unused_rng = ^rng;

    // R3
    match_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rng[ent][31] && (addr <= range_limit(rng[ent]))));
endmodule

// File: rtl/rid_way_strip.sv
module rid_way_strip
    import rid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  addr_t             addr,
    input  logic              closed,
    input  logic [1:0]        way_log,
    output addr_t             stripped,
    output logic [WAY_W-1:0]  way_idx
);
    int unsigned sh;
    addr_t       above;
    addr_t       low_mask;

    always_comb begin
        sh       = closed ? SH_CLOSED : SH_OPEN;
        above    = addr >> sh;
        low_mask = (addr_t'(1) << sh) - addr_t'(1);
        stripped = ((above >> way_log) << sh) | (addr & low_mask);
        way_idx  = WAY_W'(above) & WAY_W'((32'd1 << way_log) - 32'd1);
    end

    // R6
    way_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(way_idx) < (32'd1 << way_log));
endmodule

// File: rtl/rank_ilv_decoder.sv
module rank_ilv_decoder
    import rid_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_is_tgt,
    input  logic [ENT_W-1:0]    cfg_entry,
    input  logic [WAY_W-1:0]    cfg_way,
    input  logic [31:0]         cfg_wdata,
    input  logic                start,
    input  logic [ADDR_W-1:0]   chan_addr,
    input  logic                closed_page,
    output logic                done,
    output logic                hit,
    output logic [ADDR_W-1:0]   rank_addr,
    output logic [CR_W-1:0]     chan_rank,
    output logic [DIMM_W-1:0]   dimm,
    output logic [1:0]          rank
);
    logic [N_ENT-1:0][31:0] rng;
    word_t                  tgt_word;
    logic                   m_hit;
    logic [ENT_W-1:0]       m_ent;
    logic [1:0]             way_log;
    addr_t                  stripped;
    logic [WAY_W-1:0]       way_idx;
    addr_t                  ofs;
    res_t                   res_d, res_q;

    rid_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .is_tgt(cfg_is_tgt),
        .ent(cfg_entry), .way(cfg_way), .wdata(cfg_wdata),
        .rd_ent(m_ent), .rd_way(way_idx), .rng(rng), .tgt_word(tgt_word)
    );

    rid_range_match u_match (
        .clk(clk), .rst_n(rst_n), .rng(rng), .addr(chan_addr),
        .hit(m_hit), .ent(m_ent)
    );

    assign way_log = rng[m_ent][29:28];

    rid_way_strip u_strip (
        .clk(clk), .rst_n(rst_n), .addr(chan_addr), .closed(closed_page),
        .way_log(way_log), .stripped(stripped), .way_idx(way_idx)
    );

    assign ofs = addr_t'(tgt_word[15:2]) << OFS_SHIFT;

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (start) begin
            res_d.done = 1'b1;
            res_d.hit  = m_hit;
            if (m_hit) begin
                res_d.raddr = stripped - ofs;
                res_d.cr    = tgt_word[19:16];
            end else begin
                res_d.raddr = '0;
                res_d.cr    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done      = res_q.done;
    assign hit       = res_q.hit;
    assign rank_addr = res_q.raddr;
    assign chan_rank = res_q.cr;
    assign dimm      = res_q.cr[CR_W-1:2];
    assign rank      = res_q.cr[1:0];

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (rank_addr == '0 && chan_rank == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(rank_addr) && $stable(hit) && $stable(chan_rank)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
endmodule

// File: tb/sim_rank_ilv_decoder.sv
module sim_rank_ilv_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_is_tgt = 1'b0;
    logic [1:0]  cfg_entry = '0;
    logic [2:0]  cfg_way = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [39:0] chan_addr = '0;
    logic        closed_page = 1'b0;
    logic        done;
    logic        hit;
    logic [39:0] rank_addr;
    logic [3:0]  chan_rank;
    logic [1:0]  dimm;
    logic [1:0]  rank;

    int total = 0;
    int bad   = 0;

    logic [31:0] rng_sh [4];
    logic [31:0] tgt_sh [4][8];

    always #5 clk = ~clk;

    rank_ilv_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_tgt(cfg_is_tgt),
        .cfg_entry(cfg_entry), .cfg_way(cfg_way), .cfg_wdata(cfg_wdata),
        .start(start), .chan_addr(chan_addr), .closed_page(closed_page),
        .done(done), .hit(hit), .rank_addr(rank_addr), .chan_rank(chan_rank),
        .dimm(dimm), .rank(rank)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr_range(input int e, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_tgt = 1'b0; cfg_entry = 2'(e); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        rng_sh[e] = w;
    endtask

    task automatic wr_tgt(input int e, input int wy, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_tgt = 1'b1; cfg_entry = 2'(e); cfg_way = 3'(wy); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        tgt_sh[e][wy] = w;
    endtask

    // expected result worked out from the requirement text
    task automatic model(input logic [39:0] a, input logic cl, output logic h,
                         output logic [39:0] ra, output logic [3:0] cr);
        int          sh;
        logic [39:0] lower;
        logic [39:0] lim;
        int          hit_e;
        int          ways;
        logic [39:0] q;
        int          idx;
        sh    = cl ? 6 : 13;
        lower = '0;
        hit_e = -1;
        for (int e = 0; e < 4; e++) begin
            lim = ({29'd0, rng_sh[e][11:1]} << 29) + 40'h1FFF_FFFF;
            if (hit_e < 0 && rng_sh[e][31] && lower <= a && a <= lim) hit_e = e;
            lower = lim;
        end
        h = (hit_e >= 0);
        ra = '0;
        cr = '0;
        if (h) begin
            ways = 1 << rng_sh[hit_e][29:28];
            q    = (a >> sh) / 40'(ways);
            idx  = int'((a >> sh) % 40'(ways));
            ra   = (q << sh) + (a % (40'd1 << sh));
            ra   = ra - ({26'd0, tgt_sh[hit_e][idx][15:2]} << 26);
            cr   = tgt_sh[hit_e][idx][19:16];
        end
    endtask

    task automatic decode_and_check(input string tag, input logic [39:0] a, input logic cl);
        logic        eh;
        logic [39:0] era;
        logic [3:0]  ecr;
        model(a, cl, eh, era, ecr);
        @(negedge clk);
        start = 1'b1; chan_addr = a; closed_page = cl;
        @(negedge clk);
        start = 1'b0;
        check(tag, "done", 64'(done), 64'd1);
        check(tag, "hit", 64'(hit), 64'(eh));
        check(tag, "rank_addr", 64'(rank_addr), 64'(era));
        check(tag, "chan_rank", 64'(chan_rank), 64'(ecr));
        check("R8", "dimm", 64'(dimm), 64'(ecr >> 2));
        check("R8", "rank", 64'(rank), 64'(ecr & 4'd3));
    endtask

    task automatic t_reset;
        check("R10", "reset done", 64'(done), 64'd0);
        check("R10", "reset hit", 64'(hit), 64'd0);
        check("R10", "reset rank_addr", 64'(rank_addr), 64'd0);
        check("R11", "reset tables give miss", 64'(chan_rank), 64'd0);
    endtask

    task automatic t_one_way;
        wr_range(0, 32'h8000_0002);
        wr_tgt(0, 0, 32'h0005_0000);
        decode_and_check("R2", 40'h00_1234_5678, 1'b0);
        check("R8", "dimm hand value", 64'(dimm), 64'd1);
        check("R8", "rank hand value", 64'(rank), 64'd1);
        check("R11", "range write took effect", 64'(hit), 64'd1);
    endtask

    task automatic t_two_way_offset;
        wr_range(1, 32'h9000_0006);
        wr_tgt(1, 1, 32'h000B_0008);
        wr_tgt(1, 0, 32'h0003_0004);
        decode_and_check("R7", 40'h00_5000_2000, 1'b0);
        check("R5", "hand rank_addr", 64'(rank_addr), 64'h2000_0000);
        check("R6", "way1 chosen", 64'(chan_rank), 64'hB);
        decode_and_check("R6", 40'h00_5000_0000, 1'b0);
        check("R6", "way0 chosen", 64'(chan_rank), 64'h3);
    endtask

    task automatic t_closed_four_way;
        wr_range(1, 32'hA000_0006);
        for (int w = 0; w < 4; w++) wr_tgt(1, w, 32'(((w + 4) << 16) | (w << 2)));
        decode_and_check("R1", 40'h00_4000_00C5, 1'b1);
        check("R1", "closed shift picks way 3", 64'(chan_rank), 64'h7);
        decode_and_check("R4", 40'h00_4000_00C5, 1'b0);
        decode_and_check("R5", 40'h00_7123_4567, 1'b1);
    endtask

    task automatic t_eight_way;
        wr_range(2, 32'hB000_000E);
        for (int w = 0; w < 8; w++) wr_tgt(2, w, 32'(((w + 8) << 16) | ((w + 1) << 2)));
        decode_and_check("R4", 40'h00_8000_1FC0, 1'b1);
        decode_and_check("R4", 40'h00_9ABC_DEF0, 1'b0);
    endtask

    task automatic t_bounds;
        wr_tgt(0, 0, 32'h0005_0000);
        wr_tgt(1, 3, 32'h000E_0000);
        decode_and_check("R3", 40'h00_3FFF_FFFF, 1'b0);
        check("R3", "lowest entry wins at shared bound", 64'(chan_rank), 64'h5);
        decode_and_check("R3", 40'h00_4000_0000, 1'b0);
        wr_range(0, 32'h0000_0002);
        decode_and_check("R3", 40'h00_3FFF_FFFF, 1'b0);
        check("R3", "bound not incremented", 64'(hit), 64'd1);
        check("R2", "invalid entry skipped", 64'(chan_rank), 64'hE);
        decode_and_check("R3", 40'h00_0000_1000, 1'b0);
        check("R3", "below bound of entry 1", 64'(hit), 64'd0);
    endtask

    task automatic t_miss_and_hold;
        decode_and_check("R9", 40'h00_5000_2000, 1'b0);
        decode_and_check("R9", 40'hFF_0000_0000, 1'b0);
        check("R9", "miss zero dimm", 64'(dimm), 64'd0);
        repeat (3) @(negedge clk);
        check("R10", "done dropped", 64'(done), 64'd0);
        check("R10", "hit held", 64'(hit), 64'd0);
        decode_and_check("R10", 40'h00_4000_00C5, 1'b1);
        chan_addr = 40'hFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R10", "result held", 64'(hit), 64'd1);
        check("R10", "done low while idle", 64'(done), 64'd0);
    endtask

    initial begin
        for (int e = 0; e < 4; e++) begin
            rng_sh[e] = '0;
            for (int w = 0; w < 8; w++) tgt_sh[e][w] = '0;
        end
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_one_way();
        t_two_way_offset();
        t_closed_four_way();
        t_eight_way();
        t_bounds();
        t_miss_and_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule